// File: doc/BRIEF.md
# Configurable GPIO Port Data Register

This block is the data register of a general-purpose I/O port whose width is a parameter (eight pins by default). Every pin carries a 2-bit mode supplied from outside the block. The mode selects one of four uses for the pin:

- an alternate function;
- a driven output;
- an input with its pull-up enabled;
- an input with its pull-up disabled.

From the per-pin modes, the block derives each pin's output enable, pull-up enable and driven level. It also derives what a bus read of the register returns.

Software reaches the register over a minimal bus made of an address, a write strobe, write data and combinational read data. A write always lands in storage, but only pins in output mode show the stored bit. A read returns the stored bit for pins in alternate or output mode. For pins in either input mode it returns the pin level after a synchronizer.

Two reset inputs act differently. Power-on reset clears the storage and the synchronizer. Manual reset preserves the storage and blocks writes while it is held.

Top module: `gpio_port_reg`

## Requirements
- R1: While power-on reset (`por_n` low) is held, and after it is released, the stored data is all zeros. With every pin in mode 01, `bus_rdata` and `pin_out` read 0 after release.
- R2: A write occurs on a rising clock edge where `bus_we` is 1, `bus_addr` equals `REG_ADDR` and `mrst_n` is 1. Such a write loads `bus_wdata` into storage, whatever the pin modes are.
- R3: An edge where `bus_we` is 0, or where `bus_addr` differs from `REG_ADDR`, leaves the stored data unchanged.
- R4: For a pin in mode 00 (alternate) or mode 01 (output), bit n of `bus_rdata` equals stored bit n.
- R5: For a pin in mode 10 or mode 11 (input), bit n of `bus_rdata` equals the level of `pin_in[n]` sampled `SYNC_STAGES` rising edges earlier (2 by default).
- R6: `pin_oe[n]` is 1 exactly when pin n is in mode 01. `pin_out[n]` equals stored bit n in that mode and is 0 in every other mode.
- R7: `pin_pu[n]` is 1 exactly when pin n is in mode 10.
- R8: While `mrst_n` is low, the stored data keeps its value and writes are ignored. After `mrst_n` is released, the data present before the manual reset is still read back.
- R9: Data written while a pin is in an input or alternate mode becomes visible on `pin_out` and `bus_rdata` as soon as that pin's mode becomes 01.
- R10: Each pin follows its own mode field `pin_mode[2n+1:2n]`. Pins in different modes in the same cycle do not affect one another's read bit, output enable, pull-up or output level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| mrst_n | input | 1 | Manual reset, active low; preserves data |
| bus_addr | input | ADDR_W | Register bus address |
| bus_we | input | 1 | Register bus write strobe |
| bus_wdata | input | NUM_PINS | Register bus write data |
| bus_rdata | output | NUM_PINS | Register bus read data, combinational |
| pin_mode | input | 2*NUM_PINS | Per-pin mode: 00 alternate, 01 output, 10 input with pull-up, 11 input without pull-up |
| pin_in | input | NUM_PINS | Pin levels from the pads |
| pin_out | output | NUM_PINS | Level driven on each pin |
| pin_oe | output | NUM_PINS | Output enable per pin |
| pin_pu | output | NUM_PINS | Pull-up enable per pin |

## Verification
A write and a mode change can land on the same clock edge. So can a write and a read of a pin that is in input mode. The bench provokes the first case by switching pins from mode 11 to mode 01 at the edge that captures a new value, and it expects the new value on `pin_out` in the very next cycle. It provokes the second case by writing while pins are in input mode, with a pin level that differs from the write data. There it expects the read to keep showing the synchronized pin level and `pin_out` to stay low. Once the mode returns to 01, it expects the written value to reappear.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   typedef enum logic [1:0] {
      PM_ALT     = 2'b00,
      PM_OUT     = 2'b01,
      PM_IN_PU   = 2'b10,
      PM_IN_NOPU = 2'b11
   } pin_mode_e;

   localparam int MODE_W = 2;

   function automatic logic mode_reads_pin(input pin_mode_e m);
      return (m == PM_IN_PU) || (m == PM_IN_NOPU);
   endfunction

   function automatic logic mode_drives_pin(input pin_mode_e m);
      return m == PM_OUT;
   endfunction

   function automatic logic mode_pulls_up(input pin_mode_e m);
      return m == PM_IN_PU;
   endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
         $error("gpio_pin_sync: STAGES must be 0..4");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("gpio_pin_sync: WIDTH must be at least 1");
      end

      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];

         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               stage_q[0] <= '0;
            end else begin
               stage_q[0] <= d;
            end
         end

         for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge por_n) begin
               if (!por_n) begin
                  stage_q[s] <= '0;
               end else begin
                  stage_q[s] <= stage_q[s-1];
               end
            end
         end

         assign q = stage_q[STAGES-1];

         // cycles since power-on reset, saturating, for the latency check
         logic [2:0] since_rst;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               since_rst <= '0;
            end else if (since_rst != 3'(STAGES)) begin
               since_rst <= since_rst + 3'd1;
            end
         end

         p_latency_r5: assert property (@(posedge clk) disable iff (!por_n)
            (since_rst == 3'(STAGES)) |-> (q == $past(d, STAGES)))
            else $error("R5: synchronizer latency broken");
      end
   endgenerate

endmodule

// File: rtl/gpio_data_reg.sv
module gpio_data_reg #(
   parameter int NUM_PINS = 8,
   parameter int ADDR_W   = 4,
   parameter int REG_ADDR = 0
) (
   input  logic                clk,
   input  logic                por_n,
   input  logic                mrst_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic                we,
   input  logic [NUM_PINS-1:0] wdata,
   output logic [NUM_PINS-1:0] data_q
);

   localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

   generate
      if (REG_ADDR < 0 || REG_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("gpio_data_reg: REG_ADDR does not fit in ADDR_W bits");
      end
   endgenerate

   logic addr_hit;
   logic wr_hit;

   assign addr_hit = (addr == HIT_ADDR);
   // manual reset blocks writes but never clears storage
   assign wr_hit   = we && addr_hit && mrst_n;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         data_q <= '0;
      end else if (wr_hit) begin
         data_q <= wdata;
      end
   end

   p_write_lands_r2: assert property (@(posedge clk) disable iff (!por_n)
      (we && (addr == HIT_ADDR) && mrst_n) |=> (data_q == $past(wdata)))
      else $error("R2: write did not land");

   p_no_strobe_hold_r3: assert property (@(posedge clk) disable iff (!por_n)
      (!we || (addr != HIT_ADDR)) |=> $stable(data_q))
      else $error("R3: data changed without a write");

   p_manual_hold_r8: assert property (@(posedge clk) disable iff (!por_n)
      (!mrst_n) |=> $stable(data_q))
      else $error("R8: data changed during manual reset");

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
   import gpio_port_pkg::*;
#(
   parameter int NUM_PINS = 8
) (
   input  logic                       clk,
   input  logic                       por_n,
   input  logic [MODE_W*NUM_PINS-1:0] mode_vec,
   input  logic [NUM_PINS-1:0]        data_q,
   input  logic [NUM_PINS-1:0]        pin_sync,
   output logic [NUM_PINS-1:0]        rdata,
   output logic [NUM_PINS-1:0]        pin_out,
   output logic [NUM_PINS-1:0]        pin_oe,
   output logic [NUM_PINS-1:0]        pin_pu
);

   generate
      for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
         pin_mode_e mode;
         logic      reads_pin;
         logic      drives;

         assign mode      = pin_mode_e'(mode_vec[MODE_W*i +: MODE_W]);
         assign reads_pin = mode_reads_pin(mode);
         assign drives    = mode_drives_pin(mode);

         assign rdata[i]   = reads_pin ? pin_sync[i] : data_q[i];
         assign pin_oe[i]  = drives;
         assign pin_out[i] = drives & data_q[i];
         assign pin_pu[i]  = mode_pulls_up(mode);

         p_oe_mode_r6: assert property (@(posedge clk) disable iff (!por_n)
            pin_oe[i] |-> (mode_vec[MODE_W*i +: MODE_W] == 2'b01))
            else $error("R6: output enable outside output mode");

         p_quiet_pin_r6: assert property (@(posedge clk) disable iff (!por_n)
            !pin_oe[i] |-> !pin_out[i])
            else $error("R6: pin driven high without enable");

         p_pu_mode_r7: assert property (@(posedge clk) disable iff (!por_n)
            pin_pu[i] |-> (mode_vec[MODE_W*i +: MODE_W] == 2'b10))
            else $error("R7: pull-up outside pull-up input mode");

         p_ctl_excl_r10: assert property (@(posedge clk) disable iff (!por_n)
            $onehot0({pin_oe[i], pin_pu[i]}))
            else $error("R10: drive and pull-up both on");

         p_store_read_r4: assert property (@(posedge clk) disable iff (!por_n)
            (mode_vec[MODE_W*i+1] == 1'b0) |-> (rdata[i] == data_q[i]))
            else $error("R4: read of stored bit wrong");
      end
   endgenerate

endmodule

// File: rtl/gpio_port_reg.sv
module gpio_port_reg
   import gpio_port_pkg::*;
#(
   parameter int NUM_PINS    = 8,
   parameter int ADDR_W      = 4,
   parameter int REG_ADDR    = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       por_n,
   input  logic                       mrst_n,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic                       bus_we,
   input  logic [NUM_PINS-1:0]        bus_wdata,
   output logic [NUM_PINS-1:0]        bus_rdata,
   input  logic [MODE_W*NUM_PINS-1:0] pin_mode,
   input  logic [NUM_PINS-1:0]        pin_in,
   output logic [NUM_PINS-1:0]        pin_out,
   output logic [NUM_PINS-1:0]        pin_oe,
   output logic [NUM_PINS-1:0]        pin_pu
);

   generate
      if (NUM_PINS < 1 || NUM_PINS > 32) begin : g_bad_pins
         $error("gpio_port_reg: NUM_PINS must be 1..32");
      end
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr_w
         $error("gpio_port_reg: ADDR_W must be 1..16");
      end
   endgenerate

   logic [NUM_PINS-1:0] data_q;
   logic [NUM_PINS-1:0] pin_sync;

   gpio_data_reg #(
      .NUM_PINS (NUM_PINS),
      .ADDR_W   (ADDR_W),
      .REG_ADDR (REG_ADDR)
   ) i_data (
      .clk    (clk),
      .por_n  (por_n),
      .mrst_n (mrst_n),
      .addr   (bus_addr),
      .we     (bus_we),
      .wdata  (bus_wdata),
      .data_q (data_q)
   );

   gpio_pin_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk   (clk),
      .por_n (por_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   gpio_pin_ctrl #(
      .NUM_PINS (NUM_PINS)
   ) i_ctrl (
      .clk      (clk),
      .por_n    (por_n),
      .mode_vec (pin_mode),
      .data_q   (data_q),
      .pin_sync (pin_sync),
      .rdata    (bus_rdata),
      .pin_out  (pin_out),
      .pin_oe   (pin_oe),
      .pin_pu   (pin_pu)
   );

   p_por_clear_r1: assert property (@(posedge clk)
      (!por_n) |-> (pin_out == '0))
      else $error("R1: pin driven during power-on reset");

endmodule

// File: tb/test_gpio_port_reg.sv
module test_gpio_port_reg;

   localparam int CLK_PERIOD = 10;
   localparam int N          = 8;
   localparam int AW         = 4;
   localparam int RADDR      = 6;

   logic           clk = 1'b0;
   logic           por_n = 1'b0;
   logic           mrst_n = 1'b1;
   logic [AW-1:0]  bus_addr = '0;
   logic           bus_we = 1'b0;
   logic [N-1:0]   bus_wdata = '0;
   logic [N-1:0]   bus_rdata;
   logic [2*N-1:0] pin_mode = '0;
   logic [N-1:0]   pin_in = '0;
   logic [N-1:0]   pin_out;
   logic [N-1:0]   pin_oe;
   logic [N-1:0]   pin_pu;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_port_reg #(
      .NUM_PINS (N), .ADDR_W (AW), .REG_ADDR (RADDR), .SYNC_STAGES (2)
   ) i_gpio_port_reg (
      .clk (clk), .por_n (por_n), .mrst_n (mrst_n),
      .bus_addr (bus_addr), .bus_we (bus_we), .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata), .pin_mode (pin_mode), .pin_in (pin_in),
      .pin_out (pin_out), .pin_oe (pin_oe), .pin_pu (pin_pu)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [2*N-1:0] all_mode(input logic [1:0] m);
      return {N{m}};
   endfunction

   // expected outputs from the requirements
   function automatic logic [N-1:0] exp_rd(input logic [2*N-1:0] md, input logic [N-1:0] d, input logic [N-1:0] p);
      logic [N-1:0] r;
      for (int i = 0; i < N; i++) r[i] = md[2*i+1] ? p[i] : d[i];
      return r;
   endfunction
   function automatic logic [N-1:0] exp_oe(input logic [2*N-1:0] md);
      logic [N-1:0] r;
      for (int i = 0; i < N; i++) r[i] = (md[2*i +: 2] == 2'b01);
      return r;
   endfunction
   function automatic logic [N-1:0] exp_pu(input logic [2*N-1:0] md);
      logic [N-1:0] r;
      for (int i = 0; i < N; i++) r[i] = (md[2*i +: 2] == 2'b10);
      return r;
   endfunction

   task automatic bus_write(input logic [AW-1:0] a, input logic [N-1:0] d, input logic en);
      @(negedge clk);
      bus_addr = a; bus_we = en; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic settle(input int cycles);
      repeat (cycles) @(negedge clk);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
      end
   end

   initial begin
      logic [N-1:0] shadow;
      logic [2*N-1:0] md;

      // R1: power-on reset
      pin_mode = all_mode(2'b01);
      pin_in   = 8'hA5;
      settle(3);
      chk("R1 pin_out in reset", pin_out, 0);
      por_n = 1'b1;
      settle(1);
      chk("R1 rdata after por", bus_rdata, 0);
      chk("R1 pin_out after por", pin_out, 0);
      chk("R6 oe output mode", pin_oe, 8'hFF);
      shadow = '0;

      // R2/R4/R6: exhaustive data sweep in output mode
      for (int d = 0; d < 256; d++) begin
         bus_write(AW'(RADDR), N'(d), 1'b1);
         shadow = N'(d);
         chk("R2 R4 readback", bus_rdata, shadow);
         chk("R6 pin_out", pin_out, shadow);
      end

      // R3: wrong address / no strobe
      bus_write(AW'(RADDR ^ 1), 8'h0F, 1'b1);
      chk("R3 wrong addr", bus_rdata, shadow);
      bus_write(AW'(RADDR), 8'hF0, 1'b0);
      chk("R3 no strobe", bus_rdata, shadow);
      for (int a = 0; a < 16; a++) begin
         if (a != RADDR) begin
            bus_write(AW'(a), ~shadow, 1'b1);
            chk("R3 addr sweep", bus_rdata, shadow);
         end
      end

      // R4/R5/R6/R7: each uniform mode
      for (int m = 0; m < 4; m++) begin
         md = all_mode(2'(m));
         pin_mode = md;
         pin_in = 8'h5A;
         bus_write(AW'(RADDR), N'(8'h3C + m), 1'b1);
         shadow = N'(8'h3C + m);
         settle(2);
         chk("R4 R5 mode read", bus_rdata, exp_rd(md, shadow, pin_in));
         chk("R6 oe", pin_oe, exp_oe(md));
         chk("R6 pin_out", pin_out, shadow & exp_oe(md));
         chk("R7 pu", pin_pu, exp_pu(md));
      end

      // R5: latency of the synchronizer
      pin_mode = all_mode(2'b10);
      pin_in = 8'h00;
      settle(3);
      chk("R5 settled low", bus_rdata, 8'h00);
      pin_in = 8'hC3;
      settle(1);
      chk("R5 one edge old", bus_rdata, 8'h00);
      settle(1);
      chk("R5 two edges", bus_rdata, 8'hC3);

      // R9: write in input mode, then switch to output at the write edge
      pin_mode = all_mode(2'b11);
      bus_write(AW'(RADDR), 8'h96, 1'b1);
      shadow = 8'h96;
      chk("R9 input read keeps pin", bus_rdata, 8'hC3);
      chk("R9 pin quiet", pin_out, 8'h00);
      pin_mode = all_mode(2'b01);
      settle(1);
      chk("R9 appears on pin", pin_out, 8'h96);
      chk("R9 readback", bus_rdata, 8'h96);
      @(negedge clk);
      pin_mode = all_mode(2'b11);
      bus_addr = AW'(RADDR); bus_we = 1'b1; bus_wdata = 8'h2D;
      @(negedge clk);
      bus_we = 1'b0; pin_mode = all_mode(2'b01);
      shadow = 8'h2D;
      #1;
      chk("R9 same edge mode+write", pin_out, 8'h2D);

      // R10: mixed modes per pin
      for (int r = 0; r < 4; r++) begin
         for (int i = 0; i < N; i++) md[2*i +: 2] = 2'((i + r) % 4);
         pin_mode = md;
         pin_in = N'(8'h69 ^ (r * 8'h11));
         bus_write(AW'(RADDR), N'(8'hE1 + r * 7), 1'b1);
         shadow = N'(8'hE1 + r * 7);
         settle(2);
         chk("R10 mixed read", bus_rdata, exp_rd(md, shadow, pin_in));
         chk("R10 mixed oe", pin_oe, exp_oe(md));
         chk("R10 mixed pu", pin_pu, exp_pu(md));
         chk("R10 mixed out", pin_out, shadow & exp_oe(md));
      end

      // R8: manual reset keeps data and blocks writes
      pin_mode = all_mode(2'b01);
      bus_write(AW'(RADDR), 8'h77, 1'b1);
      @(negedge clk);
      mrst_n = 1'b0;
      bus_write(AW'(RADDR), 8'h11, 1'b1);
      chk("R8 write blocked", bus_rdata, 8'h77);
      settle(2);
      mrst_n = 1'b1;
      settle(1);
      chk("R8 data retained", bus_rdata, 8'h77);
      chk("R8 pin retained", pin_out, 8'h77);

      // R1: power-on reset clears where manual did not
      por_n = 1'b0;
      settle(2);
      por_n = 1'b1;
      settle(1);
      chk("R1 second por", bus_rdata, 8'h00);

      done = 1;
      summary();
   end

endmodule